// File: doc/BRIEF.md
# Flow-Control Request Decoder

This block sits between the logic that decides when a link partner must be throttled and the circuit that builds pause frames. Each traffic class has one request bit in a low vector and one in a high vector. The block turns these into one-cycle XOFF and XON commands for the frame builder. There is one class for plain link pause and up to eight for per-priority pause. Each class keeps a pending command until the frame builder acknowledges it. The class count and the refresh counter width are parameters.

A configuration input selects how the request vectors are read:

- **Level mode.** Each low bit is a throttle level. A rise gives XOFF, a fall gives XON, and a held high level repeats XOFF at a programmable interval.
- **Coded mode.** The high and low bits of each class form a two-bit command. A command acts when the code changes. The idle code leaves any command already pending to complete. The unused code is rejected and remembered in a sticky flag.

Every output is registered. A command pulse appears in the cycle after the clock edge that sampled the request.

Top module: `fc_req_decoder`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `xoff_pulse`, `xon_pulse`, `cmd_pending`, `cmd_is_xoff` and `code_invalid` are all zero. The stored previous request values also reset to zero.
- R2: In level mode (`cfg_coded_mode`=0), `req_hi` has no effect on any output.
- R3: In level mode, a class whose `req_lo` bit goes from 0 to 1 gives one `xoff_pulse` in the cycle after the edge that sampled the 1. A change from 1 to 0 gives one `xon_pulse` at the same latency. A bit held at 0 gives no command.
- R4: In level mode, while a class holds `req_lo` at 1 and `cfg_refresh_ivl` = K > 0, `xoff_pulse` repeats every K cycles after the pulse from the rising edge. With K = 0 there is no repeat.
- R5: In coded mode, the code of class i is {`req_hi`[i], `req_lo`[i]}. A change to 01 gives one `xon_pulse`. A change to 10 gives one `xoff_pulse`. A held code gives nothing more, and no refresh happens in this mode.
- R6: In coded mode, code 00 issues no command and leaves `cmd_pending` and `cmd_is_xoff` of that class unchanged.
- R7: In coded mode, code 11 issues no command and sets `code_invalid`[i]. That bit stays set until reset. Level mode never sets it.
- R8: Each command sets `cmd_pending`[i] and loads `cmd_is_xoff`[i] (1 = XOFF, 0 = XON). It replaces any command not yet acknowledged. If `cmd_ack`[i] is high and no new command arrives, `cmd_pending`[i] clears in the next cycle. A new command in the same cycle as an acknowledge takes priority. `cmd_is_xoff` keeps its last value.
- R9: Classes are independent. Bit i of every vector port belongs to class i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_coded_mode | input | 1 | 0 = level mode, 1 = two-bit coded mode |
| cfg_refresh_ivl | input | REFRESH_W | XOFF repeat interval in cycles for level mode; 0 disables it |
| req_lo | input | NUM_CLASSES | Level request (level mode) or low code bit (coded mode) |
| req_hi | input | NUM_CLASSES | High code bit (coded mode only) |
| cmd_ack | input | NUM_CLASSES | Frame builder has taken the pending command of the class |
| xoff_pulse | output | NUM_CLASSES | One-cycle XOFF command per class |
| xon_pulse | output | NUM_CLASSES | One-cycle XON command per class |
| cmd_pending | output | NUM_CLASSES | Class has an unacknowledged command |
| cmd_is_xoff | output | NUM_CLASSES | Kind of the latest command: 1 = XOFF, 0 = XON |
| code_invalid | output | NUM_CLASSES | Sticky flag: code 11 was seen in coded mode |

## Verification
The assertions assume three things about the inputs:

- `cmd_ack` is low while `rst` is high.
- `cfg_coded_mode` changes only while no command is in flight.
- Every input is stable across the sampling edge.

The stimulus drives all inputs on the falling clock edge. It holds `cmd_ack` at zero through every reset. It changes the mode only after all pending commands have been acknowledged, or directly after a reset. Under these conditions a pulse without a pending flag, or a flag that clears without an acknowledge, can only come from a design fault.

// File: rtl/fc_req_pkg.sv
package fc_req_pkg;

    typedef enum logic {
        MODE_LEVEL = 1'b0,
        MODE_CODED = 1'b1
    } fc_mode_e;

    typedef enum logic [1:0] {
        CMD_IDLE = 2'b00,
        CMD_XON  = 2'b01,
        CMD_XOFF = 2'b10
    } fc_cmd_e;

    // two-bit request codes in coded mode
    localparam logic [1:0] CODE_HOLD = 2'b00;
    localparam logic [1:0] CODE_XON  = 2'b01;
    localparam logic [1:0] CODE_XOFF = 2'b10;
    localparam logic [1:0] CODE_BAD  = 2'b11;

    typedef struct packed {
        fc_cmd_e cmd;
        logic    bad;
    } fc_evt_t;

    function automatic fc_evt_t decode_coded(input logic [1:0] cur,
                                             input logic [1:0] prev);
        fc_evt_t e;
        e.cmd = CMD_IDLE;
        e.bad = (cur == CODE_BAD);
        if (cur != prev) begin
            if (cur == CODE_XON)
                e.cmd = CMD_XON;
            else if (cur == CODE_XOFF)
                e.cmd = CMD_XOFF;
        end
        return e;
    endfunction

    function automatic fc_evt_t decode_level(input logic cur,
                                             input logic prev,
                                             input logic refresh_hit);
        fc_evt_t e;
        e.bad = 1'b0;
        e.cmd = CMD_IDLE;
        if (cur && !prev)
            e.cmd = CMD_XOFF;
        else if (!cur && prev)
            e.cmd = CMD_XON;
        else if (cur && refresh_hit)
            e.cmd = CMD_XOFF;
        return e;
    endfunction

endpackage

// File: rtl/fc_refresh_timer.sv
module fc_refresh_timer #(
    parameter int REFRESH_W = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 hold,
    input  logic [REFRESH_W-1:0] interval,
    output logic                 hit
);
    localparam logic [REFRESH_W-1:0] ONE = REFRESH_W'(1);

    logic [REFRESH_W-1:0] cnt_q;
    logic                 enabled;

    assign enabled = (interval != '0);
    assign hit     = hold && enabled && (cnt_q == interval - ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (!hold || hit) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + ONE;
        end
    end
endmodule

// File: rtl/fc_class_decode.sv
module fc_class_decode
    import fc_req_pkg::*;
#(
    parameter int REFRESH_W = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  fc_mode_e             mode,
    input  logic [REFRESH_W-1:0] interval,
    input  logic                 lo_bit,
    input  logic                 hi_bit,
    output fc_evt_t              evt
);
    logic prev_lo_q;
    logic prev_hi_q;
    logic level_hold;
    logic refresh_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_lo_q <= 1'b0;
            prev_hi_q <= 1'b0;
        end else begin
            prev_lo_q <= lo_bit;
            prev_hi_q <= hi_bit;
        end
    end

    assign level_hold = (mode == MODE_LEVEL) && lo_bit && prev_lo_q;

    fc_refresh_timer #(
        .REFRESH_W (REFRESH_W)
    ) timer_i (
        .clk      (clk),
        .rst      (rst),
        .hold     (level_hold),
        .interval (interval),
        .hit      (refresh_hit)
    );

    always_comb begin
        if (mode == MODE_CODED)
            evt = decode_coded({hi_bit, lo_bit}, {prev_hi_q, prev_lo_q});
        else
            evt = decode_level(lo_bit, prev_lo_q, refresh_hit);
    end
endmodule

// File: rtl/fc_cmd_slot.sv
module fc_cmd_slot
    import fc_req_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  fc_evt_t evt,
    input  logic    ack,
    output logic    xoff_pulse,
    output logic    xon_pulse,
    output logic    pending,
    output logic    is_xoff,
    output logic    invalid
);
    logic new_cmd;

    assign new_cmd = (evt.cmd != CMD_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            xoff_pulse <= 1'b0;
            xon_pulse  <= 1'b0;
            pending    <= 1'b0;
            is_xoff    <= 1'b0;
            invalid    <= 1'b0;
        end else begin
            xoff_pulse <= (evt.cmd == CMD_XOFF);
            xon_pulse  <= (evt.cmd == CMD_XON);
            if (new_cmd) begin
                pending <= 1'b1;
                is_xoff <= (evt.cmd == CMD_XOFF);
            end else if (ack) begin
                pending <= 1'b0;
            end
            if (evt.bad)
                invalid <= 1'b1;
        end
    end
endmodule

// File: rtl/fc_req_decoder.sv
module fc_req_decoder
    import fc_req_pkg::*;
#(
    parameter int NUM_CLASSES = 8,
    parameter int REFRESH_W   = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cfg_coded_mode,
    input  logic [REFRESH_W-1:0]   cfg_refresh_ivl,
    input  logic [NUM_CLASSES-1:0] req_lo,
    input  logic [NUM_CLASSES-1:0] req_hi,
    input  logic [NUM_CLASSES-1:0] cmd_ack,
    output logic [NUM_CLASSES-1:0] xoff_pulse,
    output logic [NUM_CLASSES-1:0] xon_pulse,
    output logic [NUM_CLASSES-1:0] cmd_pending,
    output logic [NUM_CLASSES-1:0] cmd_is_xoff,
    output logic [NUM_CLASSES-1:0] code_invalid
);
    fc_mode_e mode;
    assign mode = fc_mode_e'(cfg_coded_mode);

    for (genvar i = 0; i < NUM_CLASSES; i++) begin : g_class
        fc_evt_t evt;

        fc_class_decode #(
            .REFRESH_W (REFRESH_W)
        ) dec_i (
            .clk      (clk),
            .rst      (rst),
            .mode     (mode),
            .interval (cfg_refresh_ivl),
            .lo_bit   (req_lo[i]),
            .hi_bit   (req_hi[i]),
            .evt      (evt)
        );

        fc_cmd_slot slot_i (
            .clk        (clk),
            .rst        (rst),
            .evt        (evt),
            .ack        (cmd_ack[i]),
            .xoff_pulse (xoff_pulse[i]),
            .xon_pulse  (xon_pulse[i]),
            .pending    (cmd_pending[i]),
            .is_xoff    (cmd_is_xoff[i]),
            .invalid    (code_invalid[i])
        );
    end
endmodule

// File: rtl/fc_req_decoder_chk.sv
module fc_req_decoder_chk #(
    parameter int NUM_CLASSES = 8
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   cfg_coded_mode,
    input logic [NUM_CLASSES-1:0] cmd_ack,
    input logic [NUM_CLASSES-1:0] xoff_pulse,
    input logic [NUM_CLASSES-1:0] xon_pulse,
    input logic [NUM_CLASSES-1:0] cmd_pending,
    input logic [NUM_CLASSES-1:0] cmd_is_xoff,
    input logic [NUM_CLASSES-1:0] code_invalid
);
    // R3 / R5: a class never gets both kinds of command in one cycle
    p_one_kind_r3: assert property (@(posedge clk) disable iff (rst)
        (xoff_pulse & xon_pulse) == '0);

    // R8: every command pulse comes with a pending flag
    p_pulse_pending_r8: assert property (@(posedge clk) disable iff (rst)
        ((xoff_pulse | xon_pulse) & ~cmd_pending) == '0);

    // R8: the kind flag agrees with the pulse that was issued
    p_kind_match_r8: assert property (@(posedge clk) disable iff (rst)
        ((xoff_pulse & ~cmd_is_xoff) | (xon_pulse & cmd_is_xoff)) == '0);

    // R8: an acknowledge with no new command clears the pending flag
    p_ack_clears_r8: assert property (@(posedge clk) disable iff (rst)
        (($past(cmd_ack) & ~(xoff_pulse | xon_pulse) & cmd_pending) == '0));

    // R6: a pending flag falls only after an acknowledge
    p_pend_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (($past(cmd_pending) & ~$past(cmd_ack) & ~cmd_pending) == '0));

    // R7: the invalid flag is sticky
    p_inval_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (($past(code_invalid) & ~code_invalid) == '0));

    // R7: the invalid flag only rises from a sample taken in coded mode
    p_inval_coded_r7: assert property (@(posedge clk) disable iff (rst)
        (!$past(cfg_coded_mode)) |-> (($past(code_invalid) ^ code_invalid) == '0));
endmodule

bind fc_req_decoder fc_req_decoder_chk #(
    .NUM_CLASSES (NUM_CLASSES)
) chk_i (
    .clk            (clk),
    .rst            (rst),
    .cfg_coded_mode (cfg_coded_mode),
    .cmd_ack        (cmd_ack),
    .xoff_pulse     (xoff_pulse),
    .xon_pulse      (xon_pulse),
    .cmd_pending    (cmd_pending),
    .cmd_is_xoff    (cmd_is_xoff),
    .code_invalid   (code_invalid)
);

// File: tb/fc_req_decoder_tb_top.sv
module fc_req_decoder_tb_top;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int NC   = 4;
    localparam int RW   = 16;
    localparam int ROWS = 15;
    localparam int ROWW = 33;

    logic          clk = 1'b0;
    logic          rst;
    logic          cfg_coded_mode;
    logic [RW-1:0] cfg_refresh_ivl;
    logic [NC-1:0] req_lo, req_hi, cmd_ack;
    logic [NC-1:0] xoff_pulse, xon_pulse, cmd_pending, cmd_is_xoff, code_invalid;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    fc_req_decoder #(.NUM_CLASSES(NC), .REFRESH_W(RW)) dut_i (
        .clk(clk), .rst(rst), .cfg_coded_mode(cfg_coded_mode),
        .cfg_refresh_ivl(cfg_refresh_ivl), .req_lo(req_lo), .req_hi(req_hi),
        .cmd_ack(cmd_ack), .xoff_pulse(xoff_pulse), .xon_pulse(xon_pulse),
        .cmd_pending(cmd_pending), .cmd_is_xoff(cmd_is_xoff),
        .code_invalid(code_invalid)
    );

    // row: mode, hi, lo, ack | expected xoff, xon, pending, kind, invalid
    localparam logic [ROWW-1:0] TBL [0:ROWS-1] = '{
        {1'b0, 4'hF, 4'h1, 4'h0, 4'h1, 4'h0, 4'h1, 4'h1, 4'h0}, // R2 R3 rise, hi ignored
        {1'b0, 4'h0, 4'h1, 4'h0, 4'h0, 4'h0, 4'h1, 4'h1, 4'h0}, // R4 held, refresh off
        {1'b0, 4'h0, 4'h1, 4'h1, 4'h0, 4'h0, 4'h0, 4'h1, 4'h0}, // R8 ack clears
        {1'b0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h1, 4'h1, 4'h0, 4'h0}, // R3 fall -> XON
        {1'b0, 4'h0, 4'h6, 4'h0, 4'h6, 4'h0, 4'h7, 4'h6, 4'h0}, // R9 two classes rise
        {1'b0, 4'h0, 4'h4, 4'h1, 4'h0, 4'h2, 4'h6, 4'h4, 4'h0}, // R8 mixed ack/new
        {1'b0, 4'h0, 4'h0, 4'h6, 4'h0, 4'h4, 4'h4, 4'h0, 4'h0}, // R8 new beats ack
        {1'b0, 4'h0, 4'h0, 4'hF, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0}, // R3 held 0 idle
        {1'b1, 4'h0, 4'h1, 4'h0, 4'h0, 4'h1, 4'h1, 4'h0, 4'h0}, // R5 code 01
        {1'b1, 4'h2, 4'h0, 4'h0, 4'h2, 4'h0, 4'h3, 4'h2, 4'h0}, // R5 code 10, R6 00 keeps
        {1'b1, 4'h2, 4'h0, 4'h0, 4'h0, 4'h0, 4'h3, 4'h2, 4'h0}, // R5 held code, R6
        {1'b1, 4'h4, 4'h4, 4'h0, 4'h0, 4'h0, 4'h3, 4'h2, 4'h4}, // R7 code 11 ignored
        {1'b1, 4'h6, 4'h0, 4'h3, 4'h6, 4'h0, 4'h6, 4'h6, 4'h4}, // R5 R8 new beats ack
        {1'b1, 4'h0, 4'h6, 4'h0, 4'h0, 4'h6, 4'h6, 4'h0, 4'h4}, // R8 replace unacked
        {1'b1, 4'h8, 4'h8, 4'h6, 4'h0, 4'h0, 4'h0, 4'h0, 4'hC}  // R7 sticky
    };

    task automatic check(input string req, input string what,
                         input logic [NC-1:0] act, input logic [NC-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst = 1'b1; cfg_coded_mode = 1'b0; cfg_refresh_ivl = '0;
        req_lo = '0; req_hi = '0; cmd_ack = '0;
        repeat (3) @(negedge clk);
        check("R1", "pending in reset", cmd_pending, '0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "xoff after reset", xoff_pulse, '0);
        check("R1", "xon after reset", xon_pulse, '0);
        check("R1", "kind after reset", cmd_is_xoff, '0);
        check("R1", "invalid after reset", code_invalid, '0);

        for (int r = 0; r < ROWS; r++) begin
            logic [ROWW-1:0] row;
            row = TBL[r];
            cfg_coded_mode = row[32];
            req_hi  = row[31:28];
            req_lo  = row[27:24];
            cmd_ack = row[23:20];
            @(negedge clk);
            check("R3 R5", $sformatf("row %0d xoff", r), xoff_pulse, row[19:16]);
            check("R3 R5", $sformatf("row %0d xon", r), xon_pulse, row[15:12]);
            check("R8 R6", $sformatf("row %0d pending", r), cmd_pending, row[11:8]);
            check("R8", $sformatf("row %0d kind", r), cmd_is_xoff, row[7:4]);
            check("R7", $sformatf("row %0d invalid", r), code_invalid, row[3:0]);
        end

        // R1 / R7: reset clears the sticky invalid flags
        req_lo = '0; req_hi = '0; cmd_ack = '0; cfg_coded_mode = 1'b0;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R7", "invalid cleared by reset", code_invalid, '0);
        check("R1", "pending cleared by reset", cmd_pending, '0);

        // R4: refresh every 3 cycles on class 3
        cfg_refresh_ivl = 16'd3;
        req_lo = 4'h8;
        for (int t = 1; t <= 9; t++) begin
            @(negedge clk);
            check("R4", $sformatf("refresh t=%0d", t), xoff_pulse,
                  (t % 3 == 1) ? 4'h8 : 4'h0);
        end
        req_lo = 4'h0;
        @(negedge clk);
        check("R3", "xon after held level", xon_pulse, 4'h8);
        cmd_ack = 4'hF;
        @(negedge clk);
        cmd_ack = 4'h0;
        check("R8", "ack after refresh", cmd_pending, 4'h0);

        // R5: no refresh in coded mode
        cfg_coded_mode = 1'b1;
        cfg_refresh_ivl = 16'd2;
        req_hi = 4'h1; req_lo = 4'h0;
        for (int t = 1; t <= 6; t++) begin
            @(negedge clk);
            check("R5", $sformatf("coded no refresh t=%0d", t), xoff_pulse,
                  (t == 1) ? 4'h1 : 4'h0);
        end
        cmd_ack = 4'hF;
        @(negedge clk);
        cmd_ack = 4'h0;

        // R4: interval 0 disables refresh in level mode
        cfg_coded_mode = 1'b0;
        cfg_refresh_ivl = '0;
        req_hi = 4'h0; req_lo = 4'h1;
        for (int t = 1; t <= 6; t++) begin
            @(negedge clk);
            check("R4", $sformatf("refresh off t=%0d", t), xoff_pulse,
                  (t == 1) ? 4'h1 : 4'h0);
        end
        check("R7", "level mode leaves invalid clear", code_invalid, '0);

        finish_run();
    end
endmodule